// File: doc/BRIEF.md
# Multicycle RISC Core Sequencer

This block is a small 32-bit load/store processor core that takes each instruction through a fixed series of stages and runs one stage per clock. The stages are fetch, decode, execute, memory and write-back. The core does not pipeline, so exactly one instruction is in flight at any time. A stage controller moves values between a set of holding registers: the instruction word, the fall-through address, two operands, the extended immediate, the execute result, the loaded word and the branch flag. It also reads and writes a 32-entry register file in which register 0 always reads as zero.

The core has two memory ports, one for instructions and one for data. Both are read combinationally, so the data must follow the address within the same cycle. Writes to data memory take effect at the clock edge. The core handles register-register arithmetic and compare operations, arithmetic with an immediate, word loads and stores, and conditional branches that test a register against zero. How many cycles an instruction takes depends on its class.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the cycle right after it is released, the core is in its fetch cycle. It drives `imem_rd` high, drives `imem_addr` equal to `RESET_PC` (default 0), and keeps both data strobes low.
- R2: Instruction fields, numbered as Verilog bits: the opcode is [31:26], the first source register is [25:21], the second source or I-format destination is [20:16], and the R-format destination is [15:11]. The operation code of an R-format instruction is [5:0]; bits [10:6] are ignored. The 16-bit immediate is [15:0] and is always sign-extended.
- R3: Opcode 0x00 selects the register format, with destination [15:11]. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed less-than, 0x2B signed greater-than, 0x2C equal and 0x2D not-equal. A compare writes 1 or 0. Any other function code writes zero to the destination.
- R4: Immediate opcodes write their result to the register in field [20:16]. They are 0x08 add, 0x0A subtract, 0x0C and, 0x0D or and 0x0E xor, each applied to the first source and the sign-extended immediate.
- R5: Opcode 0x2B stores the second register to data address (first source + immediate). Opcode 0x23 loads the word at that address into the register in field [20:16].
- R6: Opcode 0x04 branches when the first source is zero; opcode 0x05 branches when it is not zero. A taken branch goes to the branch address + 4 + immediate; a branch that is not taken goes to the branch address + 4.
- R7: A write to register 0 is discarded, and register 0 always reads as zero.
- R8: A load takes 5 cycles from its fetch to the next fetch. A register-format operation, an immediate operation, a store, a branch and an unknown opcode each take 4.
- R9: An opcode not listed above changes no register and no memory location, and continues at its address + 4.
- R10: `dmem_we` is high for exactly one cycle, the fourth cycle of a store, and carries the address and data. `dmem_rd` is high only in the fourth cycle of a load. `imem_rd` is high only in fetch cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_rd | output | 1 | Instruction read strobe, high in fetch cycles |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_rd | output | 1 | Data read strobe for loads |
| dmem_we | output | 1 | Data write enable for stores |
| dmem_addr | output | 32 | Byte address for the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The bench uses the default `RESET_PC` of zero and the fixed 32-bit, 32-register layout from the package. Because of this, each program fits at address zero in a 256-word instruction array, and its results can be read back by storing registers to fixed slots in a 256-word data array. With a 32-bit word width, immediates of both signs reach the sign-extension path, and signed compares see operands with the top bit set. With a zero reset address, the bench can predict the exact fetch addresses and cycle numbers of a mixed program, so it checks the per-class cycle counts and the strobe timing cycle by cycle.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 16;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } stage_e;

    typedef enum logic [2:0] {
        CL_REG_ALU,
        CL_IMM_ALU,
        CL_LOAD,
        CL_STORE,
        CL_BR_ZERO,
        CL_BR_NZERO,
        CL_NOP
    } iclass_e;

    typedef enum logic [3:0] {
        AOP_ADD,
        AOP_SUB,
        AOP_AND,
        AOP_OR,
        AOP_XOR,
        AOP_SLT,
        AOP_SGT,
        AOP_SEQ,
        AOP_SNE,
        AOP_ZERO
    } aluop_e;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_BEQZ  = 6'h04;
    localparam logic [5:0] OPC_BNEZ  = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SUBI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;
    localparam logic [5:0] FN_SGT = 6'h2B;
    localparam logic [5:0] FN_SEQ = 6'h2C;
    localparam logic [5:0] FN_SNE = 6'h2D;

    typedef struct packed {
        stage_e            stage;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ir;
        logic [XLEN-1:0]   npc;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   imm;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   ldata;
        logic              take;
    } core_regs_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_core_pkg::*;
(
    input  logic [XLEN-1:0]      ir,
    output iclass_e              iclass,
    output aluop_e               alu_op,
    output logic [REG_IDX_W-1:0] src1_idx,
    output logic [REG_IDX_W-1:0] src2_idx,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [XLEN-1:0]      simm
);

    localparam int OPC_LSB = XLEN - 6;
    localparam int S1_LSB  = OPC_LSB - REG_IDX_W;
    localparam int S2_LSB  = S1_LSB - REG_IDX_W;
    localparam int RD_LSB  = S2_LSB - REG_IDX_W;

    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] unused_funct_hi;

    assign opcode          = ir[XLEN-1:OPC_LSB];
    assign funct           = ir[5:0];
    assign unused_funct_hi = ir[10:6];
    assign src1_idx        = ir[OPC_LSB-1:S1_LSB];
    assign src2_idx        = ir[S1_LSB-1:S2_LSB];
    assign simm            = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

    always_comb begin
        iclass  = CL_NOP;
        alu_op  = AOP_ADD;
        dst_idx = src2_idx;
        case (opcode)
            OPC_REG: begin
                iclass  = CL_REG_ALU;
                dst_idx = ir[S2_LSB-1:RD_LSB];
                case (funct)
                    FN_ADD:  alu_op = AOP_ADD;
                    FN_SUB:  alu_op = AOP_SUB;
                    FN_AND:  alu_op = AOP_AND;
                    FN_OR:   alu_op = AOP_OR;
                    FN_XOR:  alu_op = AOP_XOR;
                    FN_SLT:  alu_op = AOP_SLT;
                    FN_SGT:  alu_op = AOP_SGT;
                    FN_SEQ:  alu_op = AOP_SEQ;
                    FN_SNE:  alu_op = AOP_SNE;
                    default: alu_op = AOP_ZERO;
                endcase
            end
            OPC_ADDI:  begin iclass = CL_IMM_ALU; alu_op = AOP_ADD; end
            OPC_SUBI:  begin iclass = CL_IMM_ALU; alu_op = AOP_SUB; end
            OPC_ANDI:  begin iclass = CL_IMM_ALU; alu_op = AOP_AND; end
            OPC_ORI:   begin iclass = CL_IMM_ALU; alu_op = AOP_OR;  end
            OPC_XORI:  begin iclass = CL_IMM_ALU; alu_op = AOP_XOR; end
            OPC_LOAD:  iclass = CL_LOAD;
            OPC_STORE: iclass = CL_STORE;
            OPC_BEQZ:  iclass = CL_BR_ZERO;
            OPC_BNEZ:  iclass = CL_BR_NZERO;
            default:   iclass = CL_NOP;
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_core_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  aluop_e            op,
    output logic [DATA_W-1:0] result
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic lt_s;
    logic gt_s;
    logic eq;

    assign lt_s = $signed(lhs) < $signed(rhs);
    assign gt_s = $signed(lhs) > $signed(rhs);
    assign eq   = (lhs == rhs);

    always_comb begin
        case (op)
            AOP_ADD:  result = lhs + rhs;
            AOP_SUB:  result = lhs - rhs;
            AOP_AND:  result = lhs & rhs;
            AOP_OR:   result = lhs | rhs;
            AOP_XOR:  result = lhs ^ rhs;
            AOP_SLT:  result = lt_s ? ONE : '0;
            AOP_SGT:  result = gt_s ? ONE : '0;
            AOP_SEQ:  result = eq   ? ONE : '0;
            AOP_SNE:  result = eq   ? '0  : ONE;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] rd_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign rd_view[g] = '0;
        end else begin : g_cell
            logic [DATA_W-1:0] cell_d;
            logic [DATA_W-1:0] cell_q;
            always_comb begin
                cell_d = cell_q;
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    cell_d = wr_data;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else begin
                    cell_q <= cell_d;
                end
            end
            assign rd_view[g] = cell_q;
        end
    end

    assign rd_a_data = rd_view[rd_a_idx];
    assign rd_b_data = rd_view[rd_b_idx];

    // R7
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_idx) != '0) && (rd_a_idx == $past(wr_idx)))
        |-> (rd_a_data == $past(wr_data)));

    // R7
    zero_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_idx) == '0) && (rd_b_idx == '0))
        |-> (rd_b_data == '0));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        imem_rd,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic        dmem_rd,
    output logic        dmem_we,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata
);

    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

    core_regs_t cur_q;
    core_regs_t nxt_d;

    iclass_e              iclass;
    aluop_e               alu_op;
    logic [REG_IDX_W-1:0] src1_idx;
    logic [REG_IDX_W-1:0] src2_idx;
    logic [REG_IDX_W-1:0] dst_idx;
    logic [XLEN-1:0]      simm;

    logic [XLEN-1:0]      rf_a_data;
    logic [XLEN-1:0]      rf_b_data;
    logic                 rf_we;
    logic [XLEN-1:0]      rf_wdata;

    logic [XLEN-1:0]      alu_rhs;
    logic [XLEN-1:0]      alu_res;

    mc_decode u_decode (
        .ir       (cur_q.ir),
        .iclass   (iclass),
        .alu_op   (alu_op),
        .src1_idx (src1_idx),
        .src2_idx (src2_idx),
        .dst_idx  (dst_idx),
        .simm     (simm)
    );

    mc_regfile #(
        .DATA_W (XLEN),
        .IDX_W  (REG_IDX_W)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (rf_we),
        .wr_idx    (dst_idx),
        .wr_data   (rf_wdata),
        .rd_a_idx  (src1_idx),
        .rd_a_data (rf_a_data),
        .rd_b_idx  (src2_idx),
        .rd_b_data (rf_b_data)
    );

    assign alu_rhs = (iclass == CL_REG_ALU) ? cur_q.opb : cur_q.imm;

    mc_alu #(
        .DATA_W (XLEN)
    ) u_alu (
        .lhs    (cur_q.opa),
        .rhs    (alu_rhs),
        .op     (alu_op),
        .result (alu_res)
    );

    assign rf_wdata   = (iclass == CL_LOAD) ? cur_q.ldata : cur_q.res;
    assign imem_addr  = cur_q.pc;
    assign dmem_addr  = cur_q.res;
    assign dmem_wdata = cur_q.opb;

    always_comb begin
        nxt_d   = cur_q;
        rf_we   = 1'b0;
        imem_rd = 1'b0;
        dmem_rd = 1'b0;
        dmem_we = 1'b0;
        case (cur_q.stage)
            ST_FETCH: begin
                imem_rd     = 1'b1;
                nxt_d.ir    = imem_rdata;
                nxt_d.npc   = cur_q.pc + WORD_BYTES;
                nxt_d.stage = ST_DECODE;
            end
            ST_DECODE: begin
                nxt_d.opa   = rf_a_data;
                nxt_d.opb   = rf_b_data;
                nxt_d.imm   = simm;
                nxt_d.stage = ST_EXEC;
            end
            ST_EXEC: begin
                nxt_d.stage = ST_MEM;
                case (iclass)
                    CL_REG_ALU, CL_IMM_ALU: begin
                        nxt_d.res   = alu_res;
                        nxt_d.stage = ST_WB;
                    end
                    CL_LOAD, CL_STORE: begin
                        nxt_d.res = alu_res;
                    end
                    CL_BR_ZERO: begin
                        nxt_d.res  = cur_q.npc + cur_q.imm;
                        nxt_d.take = (cur_q.opa == '0);
                    end
                    CL_BR_NZERO: begin
                        nxt_d.res  = cur_q.npc + cur_q.imm;
                        nxt_d.take = (cur_q.opa != '0);
                    end
                    default: begin
                        nxt_d.take = 1'b0;
                    end
                endcase
            end
            ST_MEM: begin
                nxt_d.stage = ST_FETCH;
                nxt_d.pc    = cur_q.npc;
                case (iclass)
                    CL_STORE: begin
                        dmem_we = 1'b1;
                    end
                    CL_LOAD: begin
                        dmem_rd     = 1'b1;
                        nxt_d.ldata = dmem_rdata;
                        nxt_d.pc    = cur_q.pc;
                        nxt_d.stage = ST_WB;
                    end
                    CL_BR_ZERO, CL_BR_NZERO: begin
                        if (cur_q.take) begin
                            nxt_d.pc = cur_q.res;
                        end
                    end
                    default: begin
                        nxt_d.pc = cur_q.npc;
                    end
                endcase
            end
            ST_WB: begin
                rf_we       = 1'b1;
                nxt_d.pc    = cur_q.npc;
                nxt_d.stage = ST_FETCH;
            end
            default: begin
                nxt_d.stage = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{stage: ST_FETCH, pc: RESET_PC, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R8
    fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |=> (!imem_rd ##1 !imem_rd ##1 !imem_rd));

    // R10
    store_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> imem_rd);

    // R8
    load_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> (!imem_rd ##1 imem_rd));

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && (dmem_rd || imem_rd)) && !(dmem_rd && imem_rd));

    // R10
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;

    localparam logic [5:0] T_REG  = 6'h00;
    localparam logic [5:0] T_BEQZ = 6'h04;
    localparam logic [5:0] T_BNEZ = 6'h05;
    localparam logic [5:0] T_ADDI = 6'h08;
    localparam logic [5:0] T_SUBI = 6'h0A;
    localparam logic [5:0] T_ANDI = 6'h0C;
    localparam logic [5:0] T_ORI  = 6'h0D;
    localparam logic [5:0] T_XORI = 6'h0E;
    localparam logic [5:0] T_LW   = 6'h23;
    localparam logic [5:0] T_SW   = 6'h2B;
    localparam logic [5:0] T_BAD  = 6'h3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_rd;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        dmem_rd;
    logic        dmem_we;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [0:255];
    logic [31:0] dmem [0:255];
    int n_vec = 0;
    int n_bad = 0;
    int pc_w  = 0;

    always #2 clk = ~clk;

    assign imem_rdata = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    mc_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_rd    (imem_rd),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_rd    (dmem_rd),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [31:0] enc_r(int s1, int s2, int d, logic [5:0] fn);
        logic [31:0] w;
        w = {T_REG, s1[4:0], s2[4:0], d[4:0], 5'd0, fn};
        return w;
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int s1, int s2, int imm);
        logic [31:0] w;
        w = {op, s1[4:0], s2[4:0], imm[15:0]};
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic emit(logic [31:0] w);
        imem[pc_w] = w;
        pc_w++;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            imem[i] = enc_i(T_BEQZ, 0, 0, -4);
            dmem[i] = 32'h0;
        end
        pc_w = 0;
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        hold_reset();
        @(negedge clk);
        chk("R1 dmem_we in reset", {31'd0, dmem_we}, 32'd0);
        release_reset();
        chk("R1 imem_rd after reset", {31'd0, imem_rd}, 32'd1);
        chk("R1 imem_addr after reset", imem_addr, 32'h0);
        chk("R1 dmem_rd after reset", {31'd0, dmem_rd}, 32'd0);
    endtask

    task automatic test_alu();
        logic [31:0] exp [16];
        hold_reset();
        emit(enc_i(T_ADDI, 0, 1, 5));
        emit(enc_i(T_ADDI, 0, 2, -3));
        emit(enc_r(1, 2, 3, 6'h20));
        emit(enc_r(1, 2, 4, 6'h22));
        emit(enc_r(1, 2, 5, 6'h24));
        emit(enc_r(1, 2, 6, 6'h25));
        emit(enc_r(1, 2, 7, 6'h26));
        emit(enc_r(2, 1, 8, 6'h2A));
        emit(enc_r(2, 1, 9, 6'h2B));
        emit(enc_r(1, 1, 10, 6'h2C));
        emit(enc_r(1, 2, 11, 6'h2D));
        emit(enc_i(T_ANDI, 1, 12, 3));
        emit(enc_i(T_ORI, 1, 13, 16));
        emit(enc_i(T_XORI, 1, 14, -1));
        emit(enc_i(T_SUBI, 1, 15, 7));
        for (int k = 1; k < 16; k++) emit(enc_i(T_SW, 0, k, 'h100 + 4 * k));
        exp[1]  = 32'd5;
        exp[2]  = -32'sd3;
        exp[3]  = 32'd2;
        exp[4]  = 32'd8;
        exp[5]  = 32'd5 & 32'hFFFF_FFFD;
        exp[6]  = 32'hFFFF_FFFD;
        exp[7]  = 32'd5 ^ 32'hFFFF_FFFD;
        exp[8]  = 32'd1;
        exp[9]  = 32'd0;
        exp[10] = 32'd1;
        exp[11] = 32'd1;
        exp[12] = 32'd1;
        exp[13] = 32'h15;
        exp[14] = ~32'd5;
        exp[15] = -32'sd2;
        release_reset();
        run(200);
        for (int k = 1; k < 12; k++) chk($sformatf("R3 R2 reg-format result r%0d", k), dmem[64 + k], exp[k]);
        for (int k = 12; k < 16; k++) chk($sformatf("R4 immediate result r%0d", k), dmem[64 + k], exp[k]);
        chk("R4 R2 sign-extended add", dmem[66], exp[2]);
    endtask

    task automatic test_zero_and_unknown();
        hold_reset();
        emit(enc_i(T_ADDI, 0, 0, 7));
        emit(enc_i(T_ADDI, 0, 1, 9));
        emit(enc_r(1, 1, 0, 6'h20));
        emit(enc_i(T_SW, 0, 0, 'h200));
        emit(enc_i(T_BAD, 1, 1, 1));
        emit(enc_i(T_SW, 0, 1, 'h204));
        emit(enc_i(T_ADDI, 0, 2, 4));
        emit(enc_r(2, 2, 2, 6'h3F));
        emit(enc_i(T_SW, 0, 2, 'h208));
        emit(enc_i(T_ADDI, 0, 3, 6));
        emit(enc_i(T_SW, 0, 3, 'h20C));
        release_reset();
        run(120);
        chk("R7 register 0 after writes", dmem[128], 32'd0);
        chk("R9 unknown opcode leaves r1", dmem[129], 32'd9);
        chk("R3 unknown function code writes zero", dmem[130], 32'd0);
        chk("R9 execution continues after unknown opcode", dmem[131], 32'd6);
        chk("R9 unknown opcode no memory write", dmem[0], 32'd0);
    endtask

    task automatic test_mem();
        hold_reset();
        dmem['h320 >> 2] = 32'hDEAD_BEEF;
        emit(enc_i(T_ADDI, 0, 1, 'h300));
        emit(enc_i(T_ADDI, 0, 2, 'h1234));
        emit(enc_i(T_SW, 1, 2, 8));
        emit(enc_i(T_LW, 1, 3, 8));
        emit(enc_i(T_ADDI, 3, 4, 1));
        emit(enc_i(T_SW, 1, 4, 12));
        emit(enc_i(T_LW, 1, 5, 'h20));
        emit(enc_i(T_SW, 1, 5, -4));
        emit(enc_i(T_LW, 1, 0, 'h20));
        emit(enc_i(T_SW, 1, 0, 'h10));
        release_reset();
        run(120);
        chk("R5 store base plus offset", dmem['h308 >> 2], 32'h1234);
        chk("R5 load then use", dmem['h30C >> 2], 32'h1235);
        chk("R5 negative displacement", dmem['h2FC >> 2], 32'hDEAD_BEEF);
        chk("R7 load into register 0", dmem['h310 >> 2], 32'd0);
    endtask

    task automatic test_branch();
        hold_reset();
        emit(enc_i(T_ADDI, 0, 1, 0));
        emit(enc_i(T_BEQZ, 1, 0, 8));
        emit(enc_i(T_ADDI, 0, 2, 1));
        emit(enc_i(T_ADDI, 0, 2, 1));
        emit(enc_i(T_ADDI, 0, 3, 7));
        emit(enc_i(T_BNEZ, 1, 0, 8));
        emit(enc_i(T_ADDI, 0, 4, 2));
        emit(enc_i(T_ADDI, 0, 5, 3));
        emit(enc_i(T_ADDI, 6, 6, 1));
        emit(enc_i(T_SUBI, 5, 5, 1));
        emit(enc_i(T_BNEZ, 5, 0, -12));
        emit(enc_i(T_ADDI, 0, 7, 1));
        emit(enc_i(T_BEQZ, 7, 0, 4));
        emit(enc_i(T_ADDI, 0, 8, 5));
        emit(enc_i(T_SW, 0, 2, 'h180));
        emit(enc_i(T_SW, 0, 3, 'h184));
        emit(enc_i(T_SW, 0, 4, 'h188));
        emit(enc_i(T_SW, 0, 6, 'h18C));
        emit(enc_i(T_SW, 0, 8, 'h190));
        release_reset();
        run(250);
        chk("R6 taken forward branch skips", dmem[96], 32'd0);
        chk("R6 branch target executes", dmem[97], 32'd7);
        chk("R6 untaken branch falls through", dmem[98], 32'd2);
        chk("R6 backward loop count", dmem[99], 32'd3);
        chk("R6 untaken zero-test falls through", dmem[100], 32'd5);
    endtask

    task automatic test_timing();
        int fc [8];
        logic [31:0] fa [8];
        int nf = 0;
        int rd_cyc = -1;
        int we_cyc = -1;
        int n_we = 0;
        logic [31:0] we_a = '0;
        logic [31:0] we_d = '0;
        int exp_c [8] = '{0, 4, 8, 13, 17, 21, 25, 29};
        logic [31:0] exp_a [8] = '{32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd24, 32'd28, 32'd32};
        hold_reset();
        dmem[0] = 32'hA5A5_0001;
        emit(enc_r(0, 0, 1, 6'h20));
        emit(enc_i(T_ADDI, 0, 2, 1));
        emit(enc_i(T_LW, 0, 3, 0));
        emit(enc_i(T_SW, 0, 2, 'h40));
        emit(enc_i(T_BEQZ, 0, 0, 4));
        emit(enc_i(T_ADDI, 0, 9, 1));
        emit(enc_i(T_BNEZ, 0, 0, 8));
        emit(enc_i(T_BAD, 0, 0, 0));
        release_reset();
        for (int i = 0; i < 60; i++) begin
            if (imem_rd && nf < 8) begin
                fc[nf] = i;
                fa[nf] = imem_addr;
                nf++;
            end
            if (dmem_rd && rd_cyc < 0) rd_cyc = i;
            if (dmem_we) begin
                n_we++;
                we_cyc = i;
                we_a = dmem_addr;
                we_d = dmem_wdata;
            end
            @(negedge clk);
        end
        chk("R8 fetch count", nf, 8);
        for (int k = 0; k < 8; k++) begin
            chk($sformatf("R8 fetch %0d cycle", k), fc[k], exp_c[k]);
            chk($sformatf("R6 R9 fetch %0d address", k), fa[k], exp_a[k]);
        end
        chk("R10 load strobe cycle", rd_cyc, 11);
        chk("R10 store strobe cycle", we_cyc, 16);
        chk("R10 store strobe count", n_we, 1);
        chk("R10 store address", we_a, 32'h40);
        chk("R10 store data", we_d, 32'd1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_alu();
        test_zero_and_unknown();
        test_mem();
        test_branch();
        test_timing();
        finish_run();
    end

endmodule